// File: doc/BRIEF.md
# Free-Running Timer with Edge-Selected Input Capture

This block is a 16-bit up-counter that cannot be halted. It advances by one on each cycle in which the prescaler's `tick` input is high. When it wraps from 0xFFFF to 0x0000 it raises an overflow flag. Four capture channels share the counter. Each channel passes its pin through a two-flop synchronizer and then watches for the edge chosen for it. On that edge the channel copies the counter into its own 16-bit latch and sets its own flag.

Software reaches the block through a small register port. Writes are single-cycle strobes and reads are combinational, and every read returns a full 16-bit value. Through this port software sets the edge selects and the interrupt enables, clears flags by writing ones, and reads the counter and the latches. The counter accepts a written value only while `frz_mode` is high, which covers both test and freeze operation.

Top module: `capture_timer`

## Requirements
- R1: After reset the counter, every capture latch, every flag, the control register and `irq` are all zero.
- R2: The counter (address 0) rises by one on each clock edge where `tick` is high and wraps from 0xFFFF to 0x0000. It keeps its value on edges where `tick` is low.
- R3: A write to address 0 loads `reg_wdata` into the counter only when `frz_mode` is high, and it takes priority over `tick`. With `frz_mode` low the write is ignored. Reading never changes the counter.
- R4: Flag register bit 0 is the overflow flag. It becomes 1 on the same edge where a tick carries the counter from 0xFFFF to 0x0000.
- R5: Control bits [2c+1:2c] select the edge for channel c: 00 none, 01 rising, 10 falling, 11 both. A capture stores the counter value that is present on the cycle when the synchronized edge is seen, which is two clock edges after the pin changes. The latch is written on the third edge.
- R6: Flag bit c+1 becomes 1 on the edge that loads channel c's latch. An edge that the select does not match leaves both the latch and the flag unchanged. The latch of channel c is read at address 3+c.
- R7: Writing address 1 clears each flag whose `reg_wdata` bit is 1 and leaves the flags whose bit is 0. If a flag's set event falls on the same edge as its clear, the flag ends up set.
- R8: Control bit 8 enables the overflow interrupt and bits 9+c enable channel c. `irq` is high exactly when some flag is 1 and its enable is 1.
- R9: Address 2 reads back the control register (bits [12:0]) and address 1 reads back the flags (bits [4:0]). Unused bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Prescaler count enable |
| frz_mode | input | 1 | Test/freeze indication; permits counter writes |
| cap_in | input | 4 | Capture pins, one per channel, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle by the assertions. The counter holds without a tick and steps by one with one. A counter write outside freeze mode is dropped. A wrap sets the overflow flag. A latch moves only on a capture event and then takes that cycle's count. No flag rises without a set event, and a set event beats a clear. Other behaviour needs the bench's scenarios, because it depends on a full path from the pins to the register port. The bench sweeps all four edge selects against rising and falling pins on every channel. It checks the exact two-cycle capture latency against a counter that is running. It checks the per-enable masking of `irq`, and it creates the collision in which an overflow meets a clear in the same cycle.

// File: rtl/cap_tmr_pkg.sv
package cap_tmr_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned ADR_CNT  = 0;
  localparam int unsigned ADR_FLG  = 1;
  localparam int unsigned ADR_CTL  = 2;
  localparam int unsigned ADR_LAT0 = 3;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en  = load | tick;
    wrap    = tick & ~load & (cnt == {W{1'b1}});
    cnt_nxt = load ? load_val : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  // R2: no tick and no load keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  // R2: a tick without load advances by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt == W'($past(cnt) + 1'b1)));
  // R4: a wrap event lands on zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  edge_sel_e    sel,
  input  logic [W-1:0] cnt,
  output logic         hit,
  output logic [W-1:0] latch
);
  logic meta_q, sync_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    rise = sync_q & ~prev_q;
    fall = ~sync_q & prev_q;
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   latch <= '0;
    else if (hit) latch <= cnt;
  end

  // R5: latch changes only on a capture event
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(latch));
  // R5: a capture stores that cycle's count
  a_r5_latch_value: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (latch == $past(cnt)));
  // R6: a disabled channel never reports an event
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == EDGE_OFF) |-> !hit);
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_nxt;
  logic         flags_en;

  always_comb begin
    flags_en  = |(set | clr);
    flags_nxt = (flags & ~clr) | set;
    irq       = |(flags & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_en) flags <= flags_nxt;
  end

  // R7: a set event wins over a simultaneous clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));
  // R7: a clear without a set drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));
  // R7: no flag rises without a set event
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set)) == '0));
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import cap_tmr_pkg::*;
#(
  parameter  int CNT_W  = 16,
  parameter  int NUM_CH = 4,
  localparam int ADDR_W = $clog2(NUM_CH + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              frz_mode,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int SEL_W = 2 * NUM_CH;
  localparam int CTL_W = SEL_W + 1 + NUM_CH;
  localparam int FLG_W = NUM_CH + 1;

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic              cnt_load;
  logic              ctl_wr;
  logic [CTL_W-1:0]  ctl_q;
  logic [FLG_W-1:0]  flg_set, flg_clr, flg_en, flags;
  logic [NUM_CH-1:0] cap_hit;
  logic [CNT_W-1:0]  lat [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    cnt_load = reg_wr & frz_mode & (reg_addr == ADDR_W'(ADR_CNT));
    ctl_wr   = reg_wr & (reg_addr == ADDR_W'(ADR_CTL));
    flg_clr  = (reg_wr && reg_addr == ADDR_W'(ADR_FLG)) ? reg_wdata[FLG_W-1:0] : '0;
    flg_set  = {cap_hit, wrap};
    flg_en   = ctl_q[CTL_W-1:SEL_W];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    ctl_q <= '0;
    else if (ctl_wr) ctl_q <= reg_wdata[CTL_W-1:0];
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .load(cnt_load),
    .load_val(reg_wdata), .cnt(cnt), .wrap(wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cap_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_s_n), .pin(cap_in[c]),
      .sel(edge_sel_e'(ctl_q[2*c +: 2])), .cnt(cnt),
      .hit(cap_hit[c]), .latch(lat[c])
    );
  end

  tmr_flags #(.N(FLG_W)) u_flg (
    .clk(clk), .rst_n(rst_s_n), .set(flg_set), .clr(flg_clr),
    .en(flg_en), .flags(flags), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADR_CNT))      reg_rdata = cnt;
    else if (reg_addr == ADDR_W'(ADR_FLG)) reg_rdata = CNT_W'(flags);
    else if (reg_addr == ADDR_W'(ADR_CTL)) reg_rdata = CNT_W'(ctl_q);
    for (int i = 0; i < NUM_CH; i++)
      if (reg_addr == ADDR_W'(ADR_LAT0 + i)) reg_rdata = lat[i];
  end

  // R3: counter writes outside freeze mode are dropped
  a_r3_no_write_normal: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_wr && reg_addr == ADDR_W'(ADR_CNT) && !frz_mode && !tick) |=> $stable(cnt));
  // R4: wrap sets the overflow flag
  a_r4_ovf_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    wrap |=> flags[0]);
endmodule

// File: tb/capture_timer_tb.sv
module capture_timer_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        frz_mode = 1'b0;
  logic [3:0]  cap_in = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] v;
  logic [15:0] exp_lat [NCH];

  always #(CLK_P/2) clk = ~clk;

  capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frz_mode(frz_mode),
    .cap_in(cap_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 counter", v, 16'h0000);
    rd(3'd1, v); chk("R1 flags", v, 16'h0000);
    rd(3'd2, v); chk("R1 control", v, 16'h0000);
    for (int c = 0; c < NCH; c++) begin
      rd(3'(3 + c), v); chk("R1 latch", v, 16'h0000);
      exp_lat[c] = 16'h0000;
    end
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 ten ticks, then hold
    @(negedge clk); tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    rd(3'd0, v); chk("R2 ten ticks", v, 16'd10);
    repeat (5) @(negedge clk);
    rd(3'd0, v); chk("R2 hold without tick", v, 16'd10);
    rd(3'd0, v); chk("R3 read leaves count", v, 16'd10);

    // R3 write gating
    wr(3'd0, 16'h1234);
    rd(3'd0, v); chk("R3 write ignored in normal mode", v, 16'd10);
    frz_mode = 1'b1;
    wr(3'd0, 16'hABCD);
    rd(3'd0, v); chk("R3 write in freeze", v, 16'hABCD);

    // R4 overflow on wrap
    wr(3'd0, 16'hFFFD);
    tick = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd1, v); chk("R4 no flag before wrap", v, 16'h0000);
    @(negedge clk);
    tick = 1'b0;
    rd(3'd1, v); chk("R4 flag at wrap", v, 16'h0001);
    rd(3'd0, v); chk("R2 wrap to zero", v, 16'h0000);
    chk("R8 irq masked", {15'd0, irq}, 16'h0000);
    wr(3'd2, 16'h0100);
    chk("R8 irq overflow enabled", {15'd0, irq}, 16'h0001);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R7 zero write keeps flag", v, 16'h0001);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); chk("R7 one write clears", v, 16'h0000);
    chk("R8 irq drops", {15'd0, irq}, 16'h0000);

    // R7 set beats clear in the same cycle
    wr(3'd0, 16'hFFFF);
    tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0001;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    rd(3'd1, v); chk("R7 set wins", v, 16'h0001);
    wr(3'd1, 16'h001F);
    wr(3'd2, 16'h0000);

    // R5 latency against a running counter, channel 0 rising
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'h4000);
    tick = 1'b1; cap_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd1, v); chk("R5 no capture before sync", v, 16'h0000);
    @(negedge clk);
    tick = 1'b0;
    rd(3'd1, v); chk("R6 flag with capture", v, 16'h0002);
    rd(3'd3, v); chk("R5 latency value", v, 16'h4002);
    exp_lat[0] = 16'h4002;
    cap_in[0] = 1'b0;

    // R5/R6 sweep: channel x select x edge direction
    for (int c = 0; c < NCH; c++) begin
      for (int s = 0; s < 4; s++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic hit;
          logic [15:0] val;
          hit = (s == 3) || (s == 1 && dir == 0) || (s == 2 && dir == 1);
          val = 16'h1000 + 16'(c * 16 + s * 4 + dir);
          wr(3'd2, 16'h0000);
          cap_in[c] = (dir == 1);
          repeat (5) @(negedge clk);
          wr(3'd1, 16'h001F);
          wr(3'd2, 16'(s << (2 * c)));
          wr(3'd0, val);
          cap_in[c] = ~cap_in[c];
          repeat (5) @(negedge clk);
          if (hit) exp_lat[c] = val;
          rd(3'd1, v); chk("R6 capture flag", v, hit ? 16'(1 << (c + 1)) : 16'h0000);
          rd(3'(3 + c), v); chk("R5 latch contents", v, exp_lat[c]);
        end
      end
    end

    // R8 per-channel enable (channel 3 flag is set from the last sweep step)
    wr(3'd2, 16'h1000);
    chk("R8 irq channel 3 enabled", {15'd0, irq}, 16'h0001);
    wr(3'd2, 16'h0200);
    chk("R8 irq other channel enabled", {15'd0, irq}, 16'h0000);

    // R9 readback and unmapped address
    wr(3'd2, 16'hFFFF);
    rd(3'd2, v); chk("R9 control readback", v, 16'h1FFF);
    rd(3'd7, v); chk("R9 unmapped address", v, 16'h0000);

    summary();
  end
endmodule